// File: doc/BRIEF.md
# Raster line interrupt controller

This block raises a video-timing interrupt. It keeps a line counter that runs freely and moves up by one on each line tick. It compares that count with a 9-bit target line that software programs. When the counter steps onto the target line, a sticky raster flag is set. If the raster source is enabled, the flag pulls the active-low interrupt output down. The output stays low until software acknowledges the flag.

A small byte-wide register port connects the block to the CPU. The nine target bits are split across two registers: a low-byte register, and the top bit of a control register. Reading either of these two locations returns the live line count in the same bit positions, not the stored target. To acknowledge a flag, software writes a one to its bit. Two sequences therefore both clear the raster flag:
- writing 0xFF to the latch register;
- reading the latch register and writing the same value back.

Top module: `raster_irq_ctrl`

## Requirements
- R1: After reset the line count is 0, the target is 0, the enable mask and every latch flag are 0, and irqN is high. Register addresses are: 0 = line low byte, 1 = control, 2 = enable mask, 3 = interrupt latch.
- R2: Each cycle with lineTick high advances the line count by one at the clock edge. From LAST_LINE (default 311) it wraps to 0. A read of address 0 returns count bits 7..0. Bit 7 of a read of address 1 returns count bit 8.
- R3: A write to address 0 sets target bits 7..0. Bit 7 of a write to address 1 sets target bit 8. Bits 6..0 of address 1 are stored and read back unchanged.
- R4: Latch bit 0 (the raster flag) is set on the clock edge where a tick moves the count onto the target line. Further cycles spent on that line do not set it again.
- R5: irqN is low exactly while (latch AND enable mask) is non-zero. Enable bit 0 gates the raster flag.
- R6: Writing address 3 clears each latch bit whose data bit is 1 and leaves each bit whose data bit is 0. Writing 0xFF clears every flag, and so does writing back the value just read.
- R7: Bit 7 of a read of address 3 is 1 whenever any enabled flag is set. Bits FLAG_W-1..0 return the flags, and the other bits read 0.
- R8: When an acknowledge of the raster flag falls on the same edge as a new line match, the flag stays set.
- R9: The enable mask stores data bits FLAG_W-1..0 (FLAG_W defaults to 4). A read of address 2 returns them, with the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-cycle pulse at each new raster line |
| busSel | input | 1 | Register access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational from address) |
| irqN | output | 1 | Active-low interrupt request |

## Verification
Two functions can meet in the same cycle. One is the software acknowledge of the raster flag. The other is a new line match, which sets that flag again. The bench forces this collision with a directed case: it arrives at the target line with a tick in exactly the cycle that writes 0xFF to the latch. Random traffic also produces the collision now and then, as ticks and acknowledge writes interleave. The bench requires that the flag and the interrupt survive the collision, and judges this with a reference model in which setting takes priority over clearing.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  localparam int LINE_W = 9;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ADDR_LINE_LO = 2'd0,
    ADDR_CTRL    = 2'd1,
    ADDR_MASK    = 2'd2,
    ADDR_LATCH   = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic wrLineLo;
    logic wrCtrl;
    logic wrMask;
    logic wrAck;
  } regStrobe_t;
endpackage

// File: rtl/raster_line_counter.sv
module raster_line_counter #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 311
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  output logic [LINE_W-1:0] count,
  output logic [LINE_W-1:0] nextCount
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

  always_comb begin
    if (!advance)        nextCount = count;
    else if (count == LAST) nextCount = '0;
    else                 nextCount = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end
endmodule

// File: rtl/raster_irq_datapath.sv
module raster_irq_datapath
  import raster_irq_pkg::*;
#(
  parameter int LAST_LINE = 311,
  parameter int FLAG_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [LINE_W-1:0] lineCount,
  output logic [DATA_W-2:0] ctrlLow,
  output logic [FLAG_W-1:0] enableMask,
  output logic [FLAG_W-1:0] latchFlags,
  output logic              irqActive,
  output logic              irqN
);
  logic [DATA_W-1:0] targetLow;
  logic              targetHigh;
  logic [LINE_W-1:0] targetLine;
  logic [LINE_W-1:0] nextCount;
  logic              rasterHit;
  logic [FLAG_W-1:0] srcHit;

  raster_line_counter #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) cnt_i (
    .clk(clk), .rstN(rstN), .advance(lineTick),
    .count(lineCount), .nextCount(nextCount)
  );

  assign targetLine = {targetHigh, targetLow};
  assign rasterHit  = lineTick && (nextCount == targetLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetLow  <= '0;
      targetHigh <= 1'b0;
      ctrlLow    <= '0;
      enableMask <= '0;
    end else begin
      if (strobe.wrLineLo) targetLow <= wdata;
      if (strobe.wrCtrl) begin
        targetHigh <= wdata[DATA_W-1];
        ctrlLow    <= wdata[DATA_W-2:0];
      end
      if (strobe.wrMask) enableMask <= wdata[FLAG_W-1:0];
    end
  end

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    if (g == 0) begin : g_raster
      assign srcHit[g] = rasterHit;
    end else begin : g_spare
      assign srcHit[g] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN) latchFlags[g] <= 1'b0;
      else latchFlags[g] <= srcHit[g] | (latchFlags[g] & ~(strobe.wrAck & wdata[g]));
    end
  end

  assign irqActive = |(latchFlags & enableMask);
  assign irqN      = ~irqActive;
endmodule

// File: rtl/raster_irq_control.sv
module raster_irq_control
  import raster_irq_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [DATA_W-2:0] ctrlLow,
  input  logic [FLAG_W-1:0] enableMask,
  input  logic [FLAG_W-1:0] latchFlags,
  input  logic              irqActive,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);
  regAddr_t addr;
  logic     wrEn;

  assign addr = regAddr_t'(busAddr);
  assign wrEn = busSel && busWe;

  always_comb begin
    strobe          = '0;
    strobe.wrLineLo = wrEn && (addr == ADDR_LINE_LO);
    strobe.wrCtrl   = wrEn && (addr == ADDR_CTRL);
    strobe.wrMask   = wrEn && (addr == ADDR_MASK);
    strobe.wrAck    = wrEn && (addr == ADDR_LATCH);
  end

  always_comb begin
    busRdata = '0;
    unique case (addr)
      ADDR_LINE_LO: busRdata = lineCount[DATA_W-1:0];
      ADDR_CTRL:    busRdata = {lineCount[LINE_W-1], ctrlLow};
      ADDR_MASK:    busRdata[FLAG_W-1:0] = enableMask;
      ADDR_LATCH: begin
        busRdata[FLAG_W-1:0] = latchFlags;
        busRdata[DATA_W-1]   = irqActive;
      end
      default:      busRdata = '0;
    endcase
  end
endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import raster_irq_pkg::*;
#(
  parameter int LAST_LINE = 311,
  parameter int FLAG_W    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineTick,
  input  logic       busSel,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irqN
);
  regStrobe_t        strobe;
  logic [LINE_W-1:0] lineCount;
  logic [DATA_W-2:0] ctrlLow;
  logic [FLAG_W-1:0] enableMask;
  logic [FLAG_W-1:0] latchFlags;
  logic              irqActive;

  raster_irq_control #(.FLAG_W(FLAG_W)) ctl_i (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .lineCount(lineCount), .ctrlLow(ctrlLow), .enableMask(enableMask),
    .latchFlags(latchFlags), .irqActive(irqActive),
    .strobe(strobe), .busRdata(busRdata)
  );

  raster_irq_datapath #(.LAST_LINE(LAST_LINE), .FLAG_W(FLAG_W)) dp_i (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .strobe(strobe),
    .wdata(busWdata), .lineCount(lineCount), .ctrlLow(ctrlLow),
    .enableMask(enableMask), .latchFlags(latchFlags),
    .irqActive(irqActive), .irqN(irqN)
  );
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int LAST_LINE = 311
) (
  input logic       clk,
  input logic       rstN,
  input logic       lineTick,
  input logic       busSel,
  input logic       busWe,
  input logic [1:0] busAddr,
  input logic       ackBit0,
  input logic [8:0] lineCount,
  input logic       irqN
);
  localparam logic [8:0] LAST = 9'(LAST_LINE);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineCount <= LAST);

  // R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineTick && lineCount == LAST) |=> (lineCount == 9'd0));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == 2'd3 && ackBit0 && !lineTick) |=> irqN);

  // R5
  irq_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineTick && !(busSel && busWe)) |=> $stable(irqN));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> ($past(lineTick) || $past(busSel && busWe && busAddr == 2'd2)));
endmodule

bind raster_irq_ctrl raster_irq_chk #(.LAST_LINE(LAST_LINE)) chk_i (
  .clk(clk), .rstN(rstN), .lineTick(lineTick), .busSel(busSel),
  .busWe(busWe), .busAddr(busAddr), .ackBit0(busWdata[0]),
  .lineCount(lineCount), .irqN(irqN)
);

// File: tb/raster_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module raster_irq_ctrl_tb_top;
  localparam int LAST = 311;
  localparam int FW   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineTick = 1'b0, busSel = 1'b0, busWe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqN;

  int checks = 0, errors = 0;

  int mCnt, mTgt;
  logic [6:0] mCtrl;
  logic [FW-1:0] mEn, mLat;

  always #4 clk = ~clk;

  raster_irq_ctrl #(.LAST_LINE(LAST), .FLAG_W(FW)) dut_i (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    logic [7:0] v = '0;
    case (a)
      2'd0: v = mCnt[7:0];
      2'd1: v = {mCnt[8], mCtrl};
      2'd2: v[FW-1:0] = mEn;
      default: begin v[FW-1:0] = mLat; v[7] = |(mLat & mEn); end
    endcase
    return v;
  endfunction

  function automatic string readReq(input logic [1:0] a);
    case (a)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input bit tick, input bit sel, input bit we,
                      input logic [1:0] a, input logic [7:0] d);
    int nxt;
    bit hit;
    lineTick = tick; busSel = sel; busWe = we; busAddr = a; busWdata = d;
    #1;
    if (sel && !we) check(readReq(a), busRdata, modelRead(a));
    @(posedge clk);
    nxt = tick ? ((mCnt == LAST) ? 0 : mCnt + 1) : mCnt;
    hit = tick && (nxt == mTgt);
    if (sel && we) begin
      case (a)
        2'd0: mTgt = (mTgt & 9'h100) | d;
        2'd1: begin mTgt = (mTgt & 9'h0ff) | (int'(d[7]) << 8); mCtrl = d[6:0]; end
        2'd2: mEn = d[FW-1:0];
        default: mLat = mLat & ~d[FW-1:0];
      endcase
    end
    if (hit) mLat[0] = 1'b1;
    mCnt = nxt;
    #2;
    check("R5", irqN, (|(mLat & mEn)) ? 0 : 1);
    @(negedge clk);
    lineTick = 1'b0; busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input int exp);
    busSel = 1'b1; busWe = 1'b0; busAddr = a; #1;
    check(req, busRdata, exp);
    busSel = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    mCnt = 0; mTgt = 0; mCtrl = '0; mEn = '0; mLat = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(2'd0, "R1", 0); rd(2'd1, "R1", 0); rd(2'd2, "R1", 0); rd(2'd3, "R1", 0);
    check("R1", irqN, 1);

    // R3/R9 registers; enable raster, target 5
    step(0, 1, 1, 2'd2, 8'hFF);
    rd(2'd2, "R9", 8'h0F);
    step(0, 1, 1, 2'd1, 8'h2A);
    rd(2'd1, "R3", 8'h2A);
    step(0, 1, 1, 2'd0, 8'd5);
    // R4: ticks up to line 5
    repeat (4) step(1, 0, 0, 2'd0, 0);
    check("R4", irqN, 1);
    step(1, 0, 0, 2'd0, 0);
    check("R4", irqN, 0);
    rd(2'd3, "R7", 8'h81);
    // R6: acknowledge with 0 leaves, RMW clears
    step(0, 1, 1, 2'd3, 8'h00);
    check("R6", irqN, 0);
    rd(2'd3, "R6", 8'h81);
    v = busRdata;
    step(0, 1, 1, 2'd3, v);
    check("R6", irqN, 1);
    // R4: staying on the line does not re-fire
    repeat (3) step(0, 0, 0, 2'd0, 0);
    check("R4", irqN, 1);
    // R5: mask off gates the flag
    step(0, 1, 1, 2'd2, 8'h00);
    step(0, 1, 1, 2'd0, 8'd7);
    step(1, 0, 0, 2'd0, 0);
    step(1, 0, 0, 2'd0, 0);
    rd(2'd3, "R5", 8'h01);
    check("R5", irqN, 1);
    step(0, 1, 1, 2'd2, 8'h01);
    check("R5", irqN, 0);
    step(0, 1, 1, 2'd3, 8'hFF);
    check("R6", irqN, 1);
    // R8: ack collides with match at line 9
    step(0, 1, 1, 2'd0, 8'd8);
    step(1, 0, 0, 2'd0, 0);
    step(0, 1, 1, 2'd0, 8'd9);
    step(1, 1, 1, 2'd3, 8'hFF);
    check("R8", irqN, 0);
    step(0, 1, 1, 2'd3, 8'hFF);
    // R2/R3: target 300 uses bit 8, then wrap
    step(0, 1, 1, 2'd0, 8'd44);
    step(0, 1, 1, 2'd1, 8'h80);
    while (mCnt != 299) step(1, 0, 0, 2'd0, 0);
    check("R3", irqN, 1);
    step(1, 0, 0, 2'd0, 0);
    check("R3", irqN, 0);
    rd(2'd1, "R2", 8'h80);
    rd(2'd0, "R2", 8'd44);
    step(0, 1, 1, 2'd3, 8'hFF);
    while (mCnt != LAST) step(1, 0, 0, 2'd0, 0);
    step(1, 0, 0, 2'd0, 0);
    rd(2'd0, "R2", 0); rd(2'd1, "R2", 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom % 2) == 0;
      bit sl = ($urandom % 3) == 0;
      bit w  = $urandom % 2;
      logic [1:0] a = 2'($urandom);
      logic [7:0] d = 8'($urandom);
      if (a == 2'd0 && w) d = 8'($urandom % 24);
      if (a == 2'd1 && w) d[7] = 1'b0;
      step(tk, sl, w, a, d);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule